// File: doc/BRIEF.md
# Multicycle Instruction Step Sequencer

This block is the control state machine of a non-pipelined processor core. It walks each instruction through at most five one-clock steps (fetch, decode with register read and branch resolution, execute or address calculation, memory access, write-back) and lets each instruction class leave the walk as soon as its work is finished. Branches finish after two cycles, stores after four, and loads and ALU operations take all five.

The datapath around it (ALU, register file, instruction and data memories) is outside the block. The block only drives the enables those units need: one strobe per step, a register-file write enable, memory read and write strobes, a PC-increment enable, a PC-load enable for taken branches and a one-cycle completion pulse. It also keeps a free-running cycle counter and a retired-instruction counter, so that the measured cycles per instruction of a program can be read off directly.

The instruction class arrives already decoded from the opcode. It is used live during the decode step and held internally for the remaining steps. A synchronous clear input returns the machine to fetch at any point.

Top module: `mc_seq`

## Requirements
- R1: While `rst_n` is low, in the two clocks after its release, and in any cycle with `sync_clr` high, every strobe output is 0. Reset and a clear both zero both counters, and the next active cycle is a fetch.
- R2: In every active cycle exactly one step strobe is high. A fetch is always followed by a decode, and every step after that follows its predecessor in the order fetch, decode, execute, memory, write-back.
- R3: With class `2'b11` (branch) at decode, the instruction ends in that decode cycle (2 cycles in total). `pc_br_en` equals `br_taken` there.
- R4: With class `2'b10` (store), `mem_wr` is high in the memory step and the instruction ends there (4 cycles). There is no write-back step and no `rf_we`.
- R5: With class `2'b01` (load), `mem_rd` is high in the memory step and `rf_we` is high in the write-back step, where the instruction ends (5 cycles).
- R6: With class `2'b00` (ALU), the memory step occurs with no memory strobe, and `rf_we` is high in the write-back step, where the instruction ends (5 cycles).
- R7: `pc_inc_en` is high in every fetch cycle and in no other cycle.
- R8: `instr_done` is high for exactly one cycle, the last cycle of each instruction, and the next active cycle is a fetch.
- R9: The class is sampled in the decode cycle. Changes on `iclass` in any other cycle have no effect on the strobes.
- R10: `cyc_cnt` increments by one on every active clock and `ret_cnt` increments once per completed instruction. Both wrap modulo 2^CNT_W.
- R11: `br_taken` has no effect outside the decode step, and none for a non-branch class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sync_clr | input | 1 | Synchronous clear back to fetch |
| iclass | input | 2 | Decoded class: 00 ALU, 01 load, 10 store, 11 branch |
| br_taken | input | 1 | Branch outcome, valid in decode |
| step_fetch | output | 1 | Fetch step strobe |
| step_decode | output | 1 | Decode / register read step strobe |
| step_exec | output | 1 | Execute / address step strobe |
| step_mem | output | 1 | Memory step strobe |
| step_wb | output | 1 | Write-back step strobe |
| rf_we | output | 1 | Register-file write enable |
| mem_rd | output | 1 | Data memory read strobe |
| mem_wr | output | 1 | Data memory write strobe |
| pc_inc_en | output | 1 | PC increment enable |
| pc_br_en | output | 1 | PC load with branch target |
| instr_done | output | 1 | Last cycle of an instruction |
| cyc_cnt | output | CNT_W | Active cycle count |
| ret_cnt | output | CNT_W | Retired instruction count |

## Verification
Two functions can land in the same cycle. The completion pulse of a branch can coincide with the PC-load strobe in decode. A synchronous clear can also hit in the very cycle an instruction ends, so that the clear competes with both the retirement count and the return to fetch. The random stream applies a clear with low probability in any step, including decode of a taken branch and the final memory or write-back cycle. It also places a directed taken branch first. The bench model expects the clear to win: no strobes in that cycle, both counters at zero afterwards, and no retirement counted.

// File: rtl/mc_seq_pkg.sv
package mc_seq_pkg;

  typedef enum logic [1:0] {
    CLS_ALU    = 2'b00,
    CLS_LOAD   = 2'b01,
    CLS_STORE  = 2'b10,
    CLS_BRANCH = 2'b11
  } iclass_e;

  typedef enum logic [2:0] {
    ST_FETCH  = 3'd0,
    ST_DECODE = 3'd1,
    ST_EXEC   = 3'd2,
    ST_MEM    = 3'd3,
    ST_WB     = 3'd4
  } step_e;

  typedef struct packed {
    logic fetch;
    logic dec;
    logic exe;
    logic mem;
    logic wb;
    logic rf_we;
    logic mem_rd;
    logic mem_wr;
    logic pc_inc;
    logic pc_br;
    logic done;
  } ctl_t;

endpackage

// File: rtl/mc_seq_rst_sync.sv
module mc_seq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic run
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign run = chain_q[STAGES-1];
endmodule

// File: rtl/mc_seq_fsm.sv
module mc_seq_fsm
  import mc_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    run,
  input  logic    sync_clr,
  input  iclass_e cls_live,
  output step_e   step,
  output iclass_e cls_eff
);
  step_e   step_q, step_d;
  iclass_e cls_q, cls_d;
  logic    adv;

  assign adv     = run & ~sync_clr;
  assign cls_eff = (step_q == ST_DECODE) ? cls_live : cls_q;
  assign step    = step_q;

  always_comb begin
    step_d = step_q;
    cls_d  = cls_q;
    if (sync_clr) begin
      step_d = ST_FETCH;
    end else if (adv) begin
      case (step_q)
        ST_FETCH:  step_d = ST_DECODE;
        ST_DECODE: begin
          cls_d  = cls_live;
          step_d = (cls_live == CLS_BRANCH) ? ST_FETCH : ST_EXEC;
        end
        ST_EXEC:   step_d = ST_MEM;
        ST_MEM:    step_d = (cls_q == CLS_STORE) ? ST_FETCH : ST_WB;
        default:   step_d = ST_FETCH;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= ST_FETCH;
      cls_q  <= CLS_ALU;
    end else if (run) begin
      step_q <= step_d;
      cls_q  <= cls_d;
    end
  end
endmodule

// File: rtl/mc_seq_strobe.sv
module mc_seq_strobe
  import mc_seq_pkg::*;
(
  input  logic    en,
  input  step_e   step,
  input  iclass_e cls,
  input  logic    br_taken,
  output ctl_t    ctl
);
  ctl_t raw;

  always_comb begin
    raw = '0;
    case (step)
      ST_FETCH: begin
        raw.fetch  = 1'b1;
        raw.pc_inc = 1'b1;
      end
      ST_DECODE: begin
        raw.dec = 1'b1;
        if (cls == CLS_BRANCH) begin
          raw.pc_br = br_taken;
          raw.done  = 1'b1;
        end
      end
      ST_EXEC: raw.exe = 1'b1;
      ST_MEM: begin
        raw.mem    = 1'b1;
        raw.mem_rd = (cls == CLS_LOAD);
        raw.mem_wr = (cls == CLS_STORE);
        raw.done   = (cls == CLS_STORE);
      end
      ST_WB: begin
        raw.wb    = 1'b1;
        raw.rf_we = (cls == CLS_ALU) || (cls == CLS_LOAD);
        raw.done  = 1'b1;
      end
      default: raw = '0;
    endcase
    ctl = en ? raw : '0;
  end
endmodule

// File: rtl/mc_seq_ctr.sv
module mc_seq_ctr #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] q
);
  logic [W-1:0] q_r, q_d;

  always_comb begin
    q_d = q_r;
    if (clr)      q_d = '0;
    else if (inc) q_d = q_r + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          q_r <= '0;
    else if (clr || inc) q_r <= q_d;
  end

  assign q = q_r;
endmodule

// File: rtl/mc_seq.sv
module mc_seq
  import mc_seq_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_clr,
  input  logic [1:0]       iclass,
  input  logic             br_taken,
  output logic             step_fetch,
  output logic             step_decode,
  output logic             step_exec,
  output logic             step_mem,
  output logic             step_wb,
  output logic             rf_we,
  output logic             mem_rd,
  output logic             mem_wr,
  output logic             pc_inc_en,
  output logic             pc_br_en,
  output logic             instr_done,
  output logic [CNT_W-1:0] cyc_cnt,
  output logic [CNT_W-1:0] ret_cnt
);
  logic    run_q;
  logic    active;
  step_e   step;
  iclass_e cls_eff;
  ctl_t    ctl;

  mc_seq_rst_sync #(.STAGES(2)) u_rsync (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run_q)
  );

  assign active = run_q & ~sync_clr;

  mc_seq_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run_q),
    .sync_clr (sync_clr),
    .cls_live (iclass_e'(iclass)),
    .step     (step),
    .cls_eff  (cls_eff)
  );

  mc_seq_strobe u_strb (
    .en       (active),
    .step     (step),
    .cls      (cls_eff),
    .br_taken (br_taken),
    .ctl      (ctl)
  );

  mc_seq_ctr #(.W(CNT_W)) u_cyc (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (run_q & sync_clr),
    .inc   (active),
    .q     (cyc_cnt)
  );

  mc_seq_ctr #(.W(CNT_W)) u_ret (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (run_q & sync_clr),
    .inc   (ctl.done),
    .q     (ret_cnt)
  );

  assign step_fetch  = ctl.fetch;
  assign step_decode = ctl.dec;
  assign step_exec   = ctl.exe;
  assign step_mem    = ctl.mem;
  assign step_wb     = ctl.wb;
  assign rf_we       = ctl.rf_we;
  assign mem_rd      = ctl.mem_rd;
  assign mem_wr      = ctl.mem_wr;
  assign pc_inc_en   = ctl.pc_inc;
  assign pc_br_en    = ctl.pc_br;
  assign instr_done  = ctl.done;
endmodule

// File: rtl/mc_seq_chk.sv
module mc_seq_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run,
  input logic          sync_clr,
  input logic [1:0]    iclass,
  input logic          br_taken,
  input logic          step_fetch,
  input logic          step_decode,
  input logic          step_exec,
  input logic          step_mem,
  input logic          step_wb,
  input logic          rf_we,
  input logic          mem_rd,
  input logic          mem_wr,
  input logic          pc_inc_en,
  input logic          pc_br_en,
  input logic          instr_done,
  input logic [CW-1:0] cyc_cnt,
  input logic [CW-1:0] ret_cnt
);
  logic [4:0]  steps;
  logic [10:0] all_strb;
  assign steps    = {step_fetch, step_decode, step_exec, step_mem, step_wb};
  assign all_strb = {steps, rf_we, mem_rd, mem_wr, pc_inc_en, pc_br_en, instr_done};

  a_r1_quiet_on_clr: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_clr || !run) |-> (all_strb == '0));

  a_r1_clr_to_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    (run && sync_clr) |=> (cyc_cnt == '0) && (ret_cnt == '0));

  a_r2_one_step: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !sync_clr) |-> ($countones(steps) == 1));

  a_r2_fetch_then_decode: assert property (@(posedge clk) disable iff (!rst_n)
    (step_fetch) |=> (sync_clr || step_decode));

  a_r3_branch_load: assert property (@(posedge clk) disable iff (!rst_n)
    pc_br_en |-> (step_decode && instr_done && iclass == 2'b11 && br_taken));

  a_r4_store_ends: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> (step_mem && instr_done && !rf_we));

  a_r5_rf_in_wb: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> step_wb);

  a_r5_load_wb: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> (sync_clr || (step_wb && rf_we)));

  a_r8_done_to_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    instr_done |=> (sync_clr || step_fetch));

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    instr_done |=> !instr_done);

  a_r10_cyc_step: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !sync_clr) |=> (cyc_cnt == CW'($past(cyc_cnt) + 1'b1)));

  a_r10_ret_step: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_done) |=> (ret_cnt == CW'($past(ret_cnt) + 1'b1)));
endmodule

bind mc_seq mc_seq_chk #(.CW(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .run         (run_q),
  .sync_clr    (sync_clr),
  .iclass      (iclass),
  .br_taken    (br_taken),
  .step_fetch  (step_fetch),
  .step_decode (step_decode),
  .step_exec   (step_exec),
  .step_mem    (step_mem),
  .step_wb     (step_wb),
  .rf_we       (rf_we),
  .mem_rd      (mem_rd),
  .mem_wr      (mem_wr),
  .pc_inc_en   (pc_inc_en),
  .pc_br_en    (pc_br_en),
  .instr_done  (instr_done),
  .cyc_cnt     (cyc_cnt),
  .ret_cnt     (ret_cnt)
);

// File: tb/mc_seq_tb.sv
module mc_seq_tb;
  localparam int CW = 10;
  localparam int NCYC = 3000;

  logic clk = 1'b0;
  logic rst_n, sync_clr, br_taken;
  logic [1:0] iclass;
  logic step_fetch, step_decode, step_exec, step_mem, step_wb;
  logic rf_we, mem_rd, mem_wr, pc_inc_en, pc_br_en, instr_done;
  logic [CW-1:0] cyc_cnt, ret_cnt;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  mc_seq #(.CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .sync_clr(sync_clr), .iclass(iclass), .br_taken(br_taken),
    .step_fetch(step_fetch), .step_decode(step_decode), .step_exec(step_exec),
    .step_mem(step_mem), .step_wb(step_wb), .rf_we(rf_we), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .pc_inc_en(pc_inc_en), .pc_br_en(pc_br_en),
    .instr_done(instr_done), .cyc_cnt(cyc_cnt), .ret_cnt(ret_cnt)
  );

  // vector order: fetch dec exe mem wb rf_we mem_rd mem_wr pc_inc pc_br done
  function automatic logic [10:0] exp_vec(int step, logic [1:0] cls, logic tk);
    logic [10:0] v = '0;
    case (step)
      0: v = 11'b10000_000_1_0_0;
      1: v = (cls == 2'b11) ? {5'b01000, 3'b000, 1'b0, tk, 1'b1} : 11'b01000_000_0_0_0;
      2: v = 11'b00100_000_0_0_0;
      3: v = {5'b00010, 1'b0, cls == 2'b01, cls == 2'b10, 1'b0, 1'b0, cls == 2'b10};
      default: v = {5'b00001, cls != 2'b10, 5'b00001};
    endcase
    return v;
  endfunction

  function automatic string tag_of(int step, logic [1:0] cls);
    case (step)
      0: return "R2 R7";
      1: return (cls == 2'b11) ? "R3 R8 R11" : "R2 R11";
      2: return "R2 R9";
      3: return (cls == 2'b10) ? "R4 R8 R9" : (cls == 2'b01) ? "R5 R9" : "R6 R9";
      default: return "R5 R6 R8 R9";
    endcase
  endfunction

  function automatic logic [10:0] act_vec();
    return {step_fetch, step_decode, step_exec, step_mem, step_wb,
            rf_we, mem_rd, mem_wr, pc_inc_en, pc_br_en, instr_done};
  endfunction

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    int step;
    logic [1:0] m_cls, nxt_cls;
    logic [CW-1:0] m_cyc, m_ret;
    logic [10:0] ev;
    int n_instr;
    logic [1:0] directed [0:4];
    void'($urandom(32'd20240611));
    directed[0] = 2'b11; directed[1] = 2'b11; directed[2] = 2'b10;
    directed[3] = 2'b01; directed[4] = 2'b00;

    rst_n = 1'b0; sync_clr = 1'b0; iclass = 2'b00; br_taken = 1'b1;
    repeat (3) @(negedge clk);
    check(act_vec() == '0, "R1 in reset", 32'(act_vec()), 0);
    check(cyc_cnt == '0 && ret_cnt == '0, "R1 counters in reset", 32'(cyc_cnt), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(act_vec() == '0, "R1 release window", 32'(act_vec()), 0);
    @(posedge clk);

    step = 0; m_cls = 2'b00; m_cyc = '0; m_ret = '0; n_instr = 0;
    nxt_cls = directed[0];
    for (int c = 0; c < NCYC; c++) begin
      @(negedge clk);
      sync_clr = (c > 40) && ($urandom % 48 == 0);
      br_taken = $urandom % 2;
      // R9/R11: class and outcome scrambled outside decode
      iclass   = (step == 1) ? nxt_cls : 2'($urandom);
      if (n_instr == 0 && step == 1) br_taken = 1'b1;
      #1;
      if (sync_clr) ev = '0;
      else          ev = exp_vec(step, (step == 1) ? nxt_cls : m_cls, br_taken);
      check(act_vec() == ev, sync_clr ? "R1 clr cycle" : tag_of(step, (step == 1) ? nxt_cls : m_cls),
            32'(act_vec()), 32'(ev));
      check(cyc_cnt == m_cyc, "R10 cycle count", 32'(cyc_cnt), 32'(m_cyc));
      check(ret_cnt == m_ret, "R10 retired count", 32'(ret_cnt), 32'(m_ret));
      if (sync_clr) begin
        step = 0; m_cyc = '0; m_ret = '0;
      end else begin
        m_cyc = m_cyc + 1'b1;
        if (step == 1) m_cls = nxt_cls;
        if (ev[0]) begin
          m_ret = m_ret + 1'b1;
          step = 0;
          n_instr++;
          nxt_cls = (n_instr < 5) ? directed[n_instr] : 2'($urandom);
        end else begin
          step++;
        end
      end
    end

    @(negedge clk);
    sync_clr = 1'b1;
    #1 check(act_vec() == '0, "R1 final clear quiet", 32'(act_vec()), 0);
    @(negedge clk);
    sync_clr = 1'b0;
    #1;
    check(cyc_cnt == '0 && ret_cnt == '0, "R1 counters cleared", 32'(cyc_cnt), 0);
    check(step_fetch && pc_inc_en, "R1 fetch after clear", 32'(act_vec()), 32'(11'b10000_000_1_0_0));

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule